// File: doc/BRIEF.md
# Timer toggle output multiplexer

This block decides what one shared general-purpose output pin carries. A 2-bit source field in a timer mode register picks one of four sources:
- the ordinary port data bit;
- a toggle flip-flop driven by the end-of-count pulses of timer 0;
- a toggle flip-flop driven by the end-of-count pulses of timer 1;
- a free-running divide-by-two of the system clock.

Two load bits in the same register force the matching toggle flip-flop high. One register write can therefore select a timer, preset its output and start it.

The counters sit outside the block and deliver single-cycle end-of-count pulses. Each timer keeps its own toggle flip-flop, so changing the source does not lose either timer's state. While a timer or clock source is selected, port data writes are locked out. Port reads always return the level that is on the pin.

Top module: `tout_mux`

## Requirements
- R1: A synchronous active-low reset clears the source field to 00, the port bit to 0, both toggle flip-flops to 0 and the divider to 0, so the pin reads 0 in the first cycle after reset.
- R2: With mode bits [7:6] = 00, a port write sets the pin to the written bit from the next cycle.
- R3: Mode bits [7:6] = 01 route the timer 0 toggle flip-flop to the pin, and 10 route the timer 1 toggle flip-flop, from the cycle after the mode write.
- R4: Mode bits [7:6] = 11 drive the pin with the divide-by-two clock, which inverts on every clock cycle and starts at 0 after reset.
- R5: A mode write with bit 0 set forces the timer 0 flip-flop to 1, and one with bit 1 set forces the timer 1 flip-flop to 1.
- R6: An end-of-count pulse inverts that timer's flip-flop in the next cycle.
- R7: When a load bit and an end-of-count pulse for the same timer arrive in one cycle, the flip-flop becomes 1.
- R8: The single write 0x43 selects timer 0 and shows 1 on the pin in the next cycle, whatever the flip-flop held before.
- R9: A port write made while the field is not 00 is ignored: after the field returns to 00, the pin shows the port bit from before the write.
- R10: The port read value equals the pin level in every cycle.
- R11: A flip-flop that is not selected keeps counting its pulses and holds its state, which appears on the pin when it is selected again.
- R12: With timer 0 selected and an end-of-count pulse every 4 cycles, the pin is high for exactly half of a 32-cycle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_we | input | 1 | Write strobe for the timer mode register |
| mode_wdata | input | 8 | Mode register write data: [7:6] source, [1] timer 1 load, [0] timer 0 load |
| eoc0 | input | 1 | Timer 0 end-of-count pulse |
| eoc1 | input | 1 | Timer 1 end-of-count pulse |
| port_we | input | 1 | Port data register write strobe |
| port_wdata | input | 1 | Port data bit to write |
| pin_out | output | 1 | Level driven on the shared pin |
| port_rdata | output | 1 | Port read-back value |

## Verification
The hardest case to reach is state that stays hidden at the pin: a locked-out port write, or pulses counted by the timer that is not selected. The stimulus makes each hidden change first. It then switches the source field so that the changed state, or the lack of a change, comes out on the pin. The same-cycle clash between a load and an end-of-count is driven on purpose. So is the 0x43 write made after the timer 0 flip-flop has been set low, so that a forced 1 can be told apart from a held value.

// File: rtl/tout_pkg.sv
package tout_pkg;
   typedef enum logic [1:0] {
      SRC_PORT = 2'b00,
      SRC_T0   = 2'b01,
      SRC_T1   = 2'b10,
      SRC_HALF = 2'b11
   } src_e;
endpackage

// File: rtl/tout_tog_cell.sv
module tout_tog_cell #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic eoc,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= 1'b1;
      else if (eoc)  q <= ~q;
   end

   a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q);
   a_r6_eoc_inverts: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc && !load) |=> (q != $past(q)));
   a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!eoc && !load) |=> $stable(q));
endmodule

// File: rtl/tout_half_clk.sv
module tout_half_clk (
   input  logic clk,
   input  logic rst_n,
   output logic half
);
   always_ff @(posedge clk) begin
      if (!rst_n) half <= 1'b0;
      else        half <= ~half;
   end

   a_r4_half_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (half != $past(half)));
endmodule

// File: rtl/tout_pin_mux.sv
module tout_pin_mux
   import tout_pkg::*;
#(
   parameter int NUM_TMR = 2
) (
   input  src_e               src,
   input  logic               port_bit,
   input  logic [NUM_TMR-1:0] tog,
   input  logic               half,
   output logic               pin
);
   always_comb begin
      unique case (src)
         SRC_PORT: pin = port_bit;
         SRC_T0:   pin = tog[0];
         SRC_T1:   pin = tog[1];
         SRC_HALF: pin = half;
         default:  pin = port_bit;
      endcase
   end
endmodule

// File: rtl/tout_mux.sv
module tout_mux
   import tout_pkg::*;
#(
   parameter int CTRL_W   = 8,
   parameter int SRC_MSB  = 7,
   parameter int LOAD_LSB = 0,
   parameter int NUM_TMR  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [CTRL_W-1:0] mode_wdata,
   input  logic              eoc0,
   input  logic              eoc1,
   input  logic              port_we,
   input  logic              port_wdata,
   output logic              pin_out,
   output logic              port_rdata
);
   localparam int SRC_LSB = SRC_MSB - 1;

   if (NUM_TMR != 2) begin : g_bad_tmr
      $error("tout_mux: the source encoding defines exactly two timers");
   end
   if (SRC_MSB >= CTRL_W || SRC_LSB < 0) begin : g_bad_src
      $error("tout_mux: source field lies outside the mode register");
   end
   if (LOAD_LSB + NUM_TMR > SRC_LSB) begin : g_bad_load
      $error("tout_mux: load bits overlap the source field");
   end

   src_e               src_q;
   logic               port_q;
   logic [NUM_TMR-1:0] eoc_vec;
   logic [NUM_TMR-1:0] load_vec;
   logic [NUM_TMR-1:0] tog;
   logic               half;
   logic               unused_wdata;

   assign unused_wdata = ^mode_wdata;
   assign eoc_vec      = {eoc1, eoc0};

   always_ff @(posedge clk) begin
      if (!rst_n)       src_q <= SRC_PORT;
      else if (mode_we) src_q <= src_e'(mode_wdata[SRC_MSB:SRC_LSB]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                            port_q <= 1'b0;
      else if (port_we && src_q == SRC_PORT) port_q <= port_wdata;
   end

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      assign load_vec[i] = mode_we & mode_wdata[LOAD_LSB + i];
      tout_tog_cell #(.RST_VAL(1'b0)) u_tog (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (load_vec[i]),
         .eoc   (eoc_vec[i]),
         .q     (tog[i])
      );
   end

   tout_half_clk u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .half  (half)
   );

   tout_pin_mux #(.NUM_TMR(NUM_TMR)) u_mux (
      .src      (src_q),
      .port_bit (port_q),
      .tog      (tog),
      .half     (half),
      .pin      (pin_out)
   );

   assign port_rdata = pin_out;

   a_r9_port_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (port_we && src_q != SRC_PORT) |=> $stable(port_q));
   a_r8_select_and_load: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_we && mode_wdata[SRC_MSB:SRC_LSB] == 2'b01 && mode_wdata[LOAD_LSB])
      |=> pin_out);
   a_r2_port_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (port_we && src_q == SRC_PORT && !mode_we) |=> (pin_out == $past(port_wdata)));
   a_r10_readback: assert property (@(posedge clk) disable iff (!rst_n)
      port_rdata == pin_out);
endmodule

// File: tb/tout_mux_bench.sv
module tout_mux_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_we = 1'b0;
   logic [7:0] mode_wdata = '0;
   logic       eoc0 = 1'b0, eoc1 = 1'b0;
   logic       port_we = 1'b0, port_wdata = 1'b0;
   logic       pin_out, port_rdata;

   int checks = 0;
   int errors = 0;

   typedef struct { string req; logic exp; } sb_item_t;
   sb_item_t sb[$];

   logic [1:0] m_src;
   logic       m_port, m_div;
   logic       m_t0, m_t1;

   always #4 clk = ~clk;

   tout_mux u_tout_mux (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
      .eoc0(eoc0), .eoc1(eoc1), .port_we(port_we), .port_wdata(port_wdata),
      .pin_out(pin_out), .port_rdata(port_rdata)
   );

   function automatic logic model_pin();
      case (m_src)
         2'b00:   return m_port;
         2'b01:   return m_t0;
         2'b10:   return m_t1;
         default: return m_div;
      endcase
   endfunction

   // Driver: drive at the falling edge, advance the model, push the expectation
   task automatic cyc(input logic mwe, input logic [7:0] md, input logic e0,
                      input logic e1, input logic pwe, input logic pd,
                      input string req, input bit push = 1'b1);
      @(negedge clk);
      mode_we = mwe; mode_wdata = md; eoc0 = e0; eoc1 = e1;
      port_we = pwe; port_wdata = pd;
      if (pwe && m_src == 2'b00) m_port = pd;
      if (mwe && md[0]) m_t0 = 1'b1; else if (e0) m_t0 = ~m_t0;
      if (mwe && md[1]) m_t1 = 1'b1; else if (e1) m_t1 = ~m_t1;
      m_div = ~m_div;
      if (mwe) m_src = md[7:6];
      @(posedge clk);
      #1;
      if (push) sb.push_back('{req, model_pin()});
   endtask

   task automatic idle(input string req, input bit push = 1'b1);
      cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, req, push);
   endtask

   // Monitor: pop expectations and compare against the pins
   initial begin
      forever begin
         wait (sb.size() != 0);
         begin
            sb_item_t it;
            it = sb.pop_front();
            checks++;
            if (pin_out !== it.exp) begin
               errors++;
               $display("FAIL %s: pin_out actual=%b expected=%b", it.req, pin_out, it.exp);
            end
            checks++;
            if (port_rdata !== pin_out) begin
               errors++;
               $display("FAIL R10: port_rdata actual=%b expected=%b", port_rdata, pin_out);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int high_cnt;
      m_src = 2'b00; m_port = 1'b0; m_div = 1'b0; m_t0 = 1'b0; m_t1 = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      m_div = 1'b1;
      sb.push_back('{"R1", 1'b0});

      // R2: port mode follows writes
      cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
      cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
      cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R2");
      // R3: timer 0 selected, flip-flop still at reset value
      cyc(1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      // R9: locked-out port write
      cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
      // R6: end-of-count inverts
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
      // R5: load bit 0
      cyc(1'b1, 8'h41, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      // R7: load beats simultaneous end-of-count
      cyc(1'b1, 8'h41, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
      // R11: timer 1 counts while unselected
      cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R11");
      cyc(1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
      cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
      cyc(1'b1, 8'h82, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
      cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
      cyc(1'b1, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
      // R4: clock/2 output
      cyc(1'b1, 8'hC0, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
      for (int i = 0; i < 6; i++) idle("R4");
      cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
      // R9: back to port mode, earlier locked writes had no effect (port bit 1)
      cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, "R9");
      // R8: drive timer 0 low while unselected, then 0x43
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
      cyc(1'b1, 8'h43, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
      // R12: 50 percent duty with a pulse every 4 cycles
      wait (sb.size() == 0);
      high_cnt = 0;
      for (int i = 0; i < 32; i++) begin
         cyc(1'b0, 8'h00, (i % 4) == 3, 1'b0, 1'b0, 1'b0, "R12", 1'b0);
         if (pin_out === 1'b1) high_cnt++;
      end
      checks++;
      if (high_cnt != 16) begin
         errors++;
         $display("FAIL R12: high cycles actual=%0d expected=16", high_cnt);
      end
      idle("R6");
      wait (sb.size() == 0);
      #2;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule